// File: doc/BRIEF.md
# Two-Stage I2C SCL Divider

This block derives the serial clock timing of an I2C master from a reference clock. A 16-bit control word carries two divisor fields: a 2-bit coarse divisor and a 6-bit fine divisor. The first stage divides the reference clock by (A+1). The second stage divides the pulses of the first stage by (B+1). Each pulse from the second stage is one sub-phase tick. A phase sequencer counts 22 sub-phase ticks per SCL period, so the SCL rate is the reference rate divided by 22·(A+1)·(B+1).

A bit engine uses the outputs in three ways. The free-running level `scl_high_o` shows whether the current phase belongs to the low half or the high half of SCL. The single-cycle strobes `scl_rise_tick_o` and `scl_fall_tick_o` mark the SCL transitions. `sub_tick_o` gives the sub-phase timebase. The low byte of the control word holds the bit engine's mode flags and is ignored here. An enable input starts and stops the whole timebase.

Top module: `scl_tick_gen`

## Requirements
- R1: The coarse divisor A is taken from control bits [15:14] and the fine divisor B from bits [13:8]. With enable held high, `sub_tick_o` pulses for one cycle every (A+1)·(B+1) reference cycles. Counting the first enabled cycle as cycle 0, the first pulse falls in cycle (A+1)·(B+1)−1.
- R2: The phase counter advances on each sub-phase tick and runs 0 to 21, then wraps to 0. `scl_high_o` is 0 in phases 0 to 10 and 1 in phases 11 to 21, so one SCL period lasts 22·(A+1)·(B+1) cycles.
- R3: `scl_rise_tick_o` pulses together with the sub-phase tick that leaves phase 10. `scl_fall_tick_o` pulses together with the sub-phase tick that leaves phase 21. Neither strobe pulses at any other time.
- R4: Control bits [7:0] have no effect. A control write whose bits [15:8] equal the current divisors leaves every count and output sequence undisturbed.
- R5: A control write that changes A or B sets both stage counters and the phase counter to zero at the clock edge that takes the write. Counting restarts with the new divisors from the next cycle.
- R6: While `en_i` is low, no strobe is emitted, the counters are cleared at the next edge and `scl_high_o` is low. Raising `en_i` restarts the sequence from phase 0 as in R1.
- R7: After reset, both divisors are 0, all outputs are low and all counters are zero. Enabling without a control write gives one sub-phase tick every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enables counting; low holds all counters at zero |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 16 | Control word; [15:14] coarse divisor, [13:8] fine divisor, [7:0] ignored |
| sub_tick_o | output | 1 | One-cycle sub-phase tick |
| scl_high_o | output | 1 | SCL half indicator, 1 in phases 11 to 21 |
| scl_rise_tick_o | output | 1 | One-cycle strobe on the low-to-high phase boundary |
| scl_fall_tick_o | output | 1 | One-cycle strobe at the end of the SCL period |

## Verification
The assertions check the following on every cycle:
- the stage counters never pass their divisors;
- `scl_high_o` changes only after a sub-phase tick, a disable or a reload;
- each edge strobe coincides with a sub-phase tick and is followed by the matching SCL level;
- a divisor-changing write zeroes every counter;
- a same-divisor write does not reset the phase.

Only the bench scenarios can show the exact tick spacing of (A+1)·(B+1) cycles for many divisor pairs, the placement of the first tick after enable or reload, and the uninterrupted continuation across a mode-only write. The bench compares every output against an index-based model over whole SCL periods to show these.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int CTRL_W     = 16;
  localparam int DIV_A_W    = 2;
  localparam int DIV_B_W    = 6;
  localparam int DIV_A_LSB  = 14;
  localparam int DIV_B_LSB  = 8;
  localparam int PHASES     = 22;
  localparam int PHASE_W    = $clog2(PHASES);
  localparam int HIGH_START = PHASES / 2;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
  import scl_div_pkg::*;
#(
  parameter int CW    = CTRL_W,
  parameter int AW    = DIV_A_W,
  parameter int BW    = DIV_B_W,
  parameter int A_LSB = DIV_A_LSB,
  parameter int B_LSB = DIV_B_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  output logic [AW-1:0] div_a_o,
  output logic [BW-1:0] div_b_o,
  output logic          reload_o
);
  logic [AW-1:0] wr_a;
  logic [BW-1:0] wr_b;
  logic          unused_mode;

  assign wr_a = wdata_i[A_LSB +: AW];
  assign wr_b = wdata_i[B_LSB +: BW];
  // mode flags belong to the bit engine
  assign unused_mode = ^wdata_i[B_LSB-1:0];

  assign reload_o = we_i && ((wr_a != div_a_o) || (wr_b != div_b_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_a_o <= '0;
      div_b_o <= '0;
    end else if (reload_o) begin
      div_a_o <= wr_a;
      div_b_o <= wr_b;
    end
  end
endmodule

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         tick_o
);
  logic at_limit;

  assign at_limit = (cnt_o == limit_i);
  assign tick_o   = run_i && !clear_i && step_i && at_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_o <= '0;
    else if (!run_i || clear_i) cnt_o <= '0;
    else if (step_i)            cnt_o <= at_limit ? '0 : cnt_o + 1'b1;
  end
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_div_pkg::*;
#(
  parameter int NPH = PHASES,
  parameter int PW  = PHASE_W,
  parameter int HI  = HIGH_START
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clear_i,
  input  logic          step_i,
  output logic [PW-1:0] phase_o,
  output logic          scl_high_o,
  output logic          rise_tick_o,
  output logic          fall_tick_o
);
  localparam logic [PW-1:0] LAST_PH = PW'(NPH - 1);
  localparam logic [PW-1:0] PRE_HI  = PW'(HI - 1);
  localparam logic [PW-1:0] HI_PH   = PW'(HI);

  assign scl_high_o  = (phase_o >= HI_PH);
  assign rise_tick_o = step_i && (phase_o == PRE_HI);
  assign fall_tick_o = step_i && (phase_o == LAST_PH);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                phase_o <= '0;
    else if (!run_i || clear_i) phase_o <= '0;
    else if (step_i)            phase_o <= (phase_o == LAST_PH) ? '0 : phase_o + 1'b1;
  end
endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
  import scl_div_pkg::*;
#(
  parameter int CW = CTRL_W,
  parameter int AW = DIV_A_W,
  parameter int BW = DIV_B_W,
  parameter int PW = PHASE_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          ctrl_we_i,
  input  logic [CW-1:0] ctrl_wdata_i,
  output logic          sub_tick_o,
  output logic          scl_high_o,
  output logic          scl_rise_tick_o,
  output logic          scl_fall_tick_o
);
  logic [AW-1:0] div_a, cnt_a;
  logic [BW-1:0] div_b, cnt_b;
  logic [PW-1:0] phase;
  logic          reload, tick_a, tick_b;

  scl_div_cfg #(.CW(CW), .AW(AW), .BW(BW)) u_cfg (
    .clk_i, .rst_ni,
    .we_i     (ctrl_we_i),
    .wdata_i  (ctrl_wdata_i),
    .div_a_o  (div_a),
    .div_b_o  (div_b),
    .reload_o (reload)
  );

  scl_div_stage #(.W(AW)) u_stage_a (
    .clk_i, .rst_ni,
    .run_i   (en_i),
    .clear_i (reload),
    .step_i  (1'b1),
    .limit_i (div_a),
    .cnt_o   (cnt_a),
    .tick_o  (tick_a)
  );

  scl_div_stage #(.W(BW)) u_stage_b (
    .clk_i, .rst_ni,
    .run_i   (en_i),
    .clear_i (reload),
    .step_i  (tick_a),
    .limit_i (div_b),
    .cnt_o   (cnt_b),
    .tick_o  (tick_b)
  );

  scl_phase_seq #(.PW(PW)) u_seq (
    .clk_i, .rst_ni,
    .run_i       (en_i),
    .clear_i     (reload),
    .step_i      (tick_b),
    .phase_o     (phase),
    .scl_high_o  (scl_high_o),
    .rise_tick_o (scl_rise_tick_o),
    .fall_tick_o (scl_fall_tick_o)
  );

  assign sub_tick_o = tick_b;
endmodule

// File: rtl/scl_tick_gen_chk.sv
module scl_tick_gen_chk
  import scl_div_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                en_i,
  input logic                ctrl_we_i,
  input logic [CTRL_W-1:0]   ctrl_wdata_i,
  input logic                sub_tick_o,
  input logic                scl_high_o,
  input logic                scl_rise_tick_o,
  input logic                scl_fall_tick_o,
  input logic [DIV_A_W-1:0]  div_a_i,
  input logic [DIV_B_W-1:0]  div_b_i,
  input logic [DIV_A_W-1:0]  cnt_a_i,
  input logic [DIV_B_W-1:0]  cnt_b_i,
  input logic [PHASE_W-1:0]  phase_i
);
  logic same_wr, diff_wr;
  assign same_wr = ctrl_we_i &&
                   (ctrl_wdata_i[DIV_A_LSB +: DIV_A_W] == div_a_i) &&
                   (ctrl_wdata_i[DIV_B_LSB +: DIV_B_W] == div_b_i);
  assign diff_wr = ctrl_we_i && !same_wr;

  // R1
  cnt_a_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_a_i <= div_a_i);
  // R1
  cnt_b_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_b_i <= div_b_i);
  // R2
  scl_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(scl_high_o) |-> ($past(sub_tick_o) || !$past(en_i) || $past(diff_wr)));
  // R2
  phase_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i < PHASE_W'(PHASES));
  // R3
  rise_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_rise_tick_o || scl_fall_tick_o) |-> sub_tick_o);
  // R3
  rise_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_rise_tick_o |=> scl_high_o);
  // R3
  fall_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_fall_tick_o |=> !scl_high_o);
  // R4
  same_wr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (same_wr && en_i) |=> ((phase_i == $past(phase_i)) || $past(sub_tick_o)));
  // R5
  reload_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    diff_wr |=> (phase_i == '0 && cnt_a_i == '0 && cnt_b_i == '0));
  // R6
  idle_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (phase_i == '0 && !scl_high_o));
  // R6
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !(sub_tick_o || scl_rise_tick_o || scl_fall_tick_o));
endmodule

bind scl_tick_gen scl_tick_gen_chk u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_i),
  .ctrl_we_i       (ctrl_we_i),
  .ctrl_wdata_i    (ctrl_wdata_i),
  .sub_tick_o      (sub_tick_o),
  .scl_high_o      (scl_high_o),
  .scl_rise_tick_o (scl_rise_tick_o),
  .scl_fall_tick_o (scl_fall_tick_o),
  .div_a_i         (div_a),
  .div_b_i         (div_b),
  .cnt_a_i         (cnt_a),
  .cnt_b_i         (cnt_b),
  .phase_i         (phase)
);

// File: tb/scl_tick_gen_tb.sv
`timescale 1ns/1ps
module scl_tick_gen_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        ctrl_we_i = 1'b0;
  logic [15:0] ctrl_wdata_i = '0;
  logic        sub_tick_o, scl_high_o, scl_rise_tick_o, scl_fall_tick_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  scl_tick_gen dut_i (.*);

  function automatic int div_n(input int a, input int b);
    return (a + 1) * (b + 1);
  endfunction

  function automatic logic [15:0] ctrl_word(input int a, input int b, input int mode);
    return {a[1:0], b[5:0], mode[7:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs against sample index i of a run with divide n
  task automatic check_idx(input int i, input int n, input string req);
    int  ph;
    bit  tk;
    ph = (i / n) % 22;
    tk = ((i % n) == n - 1);
    chk(sub_tick_o == tk, {req, " sub_tick"}, sub_tick_o, tk);
    chk(scl_high_o == (ph >= 11), {req, " R2 scl_high"}, scl_high_o, ph >= 11);
    chk(scl_rise_tick_o == (tk && ph == 10), {req, " R3 rise"}, scl_rise_tick_o, tk && ph == 10);
    chk(scl_fall_tick_o == (tk && ph == 21), {req, " R3 fall"}, scl_fall_tick_o, tk && ph == 21);
  endtask

  // continue a stream from index start; optional mode-only write at index wr_at
  task automatic run_stream(input int a, input int b, input int start, input int len,
                            input int wr_at, input string req);
    int n;
    n = div_n(a, b);
    for (int i = start; i < start + len; i++) begin
      @(negedge clk_i); #1;
      check_idx(i, n, req);
      ctrl_we_i = 1'b0;
      if (i == wr_at) begin
        ctrl_we_i    = 1'b1;
        ctrl_wdata_i = ctrl_word(a, b, $urandom_range(255));
      end
    end
    ctrl_we_i = 1'b0;
  endtask

  // divisor change while running; next sample is index 0 with new divisors
  task automatic reload_run(input int a, input int b, input int mode, input string req);
    int n;
    n = div_n(a, b);
    @(negedge clk_i); #1;
    ctrl_we_i    = 1'b1;
    ctrl_wdata_i = ctrl_word(a, b, mode);
    @(negedge clk_i); #1;
    ctrl_we_i = 1'b0;
    check_idx(0, n, req);
    run_stream(a, b, 1, 23 * n + 2, -1, req);
  endtask

  task automatic disable_check(input int cycles);
    @(negedge clk_i); #1;
    en_i = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk_i); #1;
      chk(!sub_tick_o && !scl_rise_tick_o && !scl_fall_tick_o, "R6 idle ticks",
          {sub_tick_o, scl_rise_tick_o, scl_fall_tick_o}, 0);
      chk(!scl_high_o, "R6 idle scl", scl_high_o, 0);
    end
  endtask

  task automatic enable_run(input int a, input int b, input int len, input string req);
    en_i = 1'b1;
    #1;
    check_idx(0, div_n(a, b), req);
    run_stream(a, b, 1, len, -1, req);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int a, b;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    // R7 reset state
    chk(!sub_tick_o && !scl_high_o && !scl_rise_tick_o && !scl_fall_tick_o, "R7 in reset",
        {sub_tick_o, scl_high_o, scl_rise_tick_o, scl_fall_tick_o}, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    #1;
    chk(!sub_tick_o && !scl_high_o, "R7 after reset", {sub_tick_o, scl_high_o}, 0);
    // R7 default divisors give a tick every cycle; R1 R2 R3 basic
    @(negedge clk_i);
    enable_run(0, 0, 50, "R7");
    disable_check(4);
    // R1 directed maximum
    @(negedge clk_i); #1;
    ctrl_we_i = 1'b1; ctrl_wdata_i = ctrl_word(3, 63, 8'h5a);
    @(negedge clk_i); #1; ctrl_we_i = 1'b0;
    chk(!sub_tick_o, "R6 write while idle", sub_tick_o, 0);
    @(negedge clk_i);
    enable_run(3, 63, 22 * 256 + 300, "R1 max");
    // R5 divisor change mid-run
    reload_run(1, 5, 8'h00, "R5 change");
    // R4 mode-only writes keep the stream
    run_stream(1, 5, 23 * 12 + 3, 200, 23 * 12 + 40, "R4 mode write");
    // R6 disable and restart
    disable_check(6);
    @(negedge clk_i);
    enable_run(1, 5, 100, "R6 restart");
    // R1 R5 random divisor pairs
    for (int t = 0; t < 6; t++) begin
      a = $urandom_range(3);
      b = $urandom_range(63);
      if (div_n(a, b) == div_n(1, 5) && a == 1 && b == 5) b = 6;
      reload_run(a, b, $urandom_range(255), "R1 R5 random");
      run_stream(a, b, 23 * div_n(a, b) + 3, 60, 23 * div_n(a, b) + 10, "R4 random");
      disable_check(2);
      @(negedge clk_i);
      enable_run(a, b, 2 * div_n(a, b) + 2, "R6 random");
    end
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule